// File: doc/BRIEF.md
# SDR SDRAM Command and Refresh Controller

This block sits between a simple single-beat request port and the command pins of a single-data-rate SDRAM. After reset it keeps the device idle for the power-up wait, then precharges all banks, runs a fixed number of auto-refresh cycles and loads the mode register. After that it serves one request at a time with a closed-page policy: it opens the addressed row, issues the read or write once the row-to-column delay has passed, and closes the row again, either with an auto-precharge flag on the column command or with an explicit precharge.

All device delays are parameters in picoseconds. They are turned into clock counts at elaboration: delays that must be at least a given time round up, and the refresh interval rounds down so that no row ever waits too long. A refresh timer raises a request once per interval. The controller serves it at the next point where no access is in flight, ahead of any waiting request. When nothing is pending and no refresh is due, the controller lowers the clock enable to put the device in power-down. It raises the clock enable one cycle before it issues the next command. The only read-side data path is a strobe that marks the cycle in which read data is valid on the device pins.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: During reset and right after it, the pins show NOP, clock enable is high, `req_ready`, `init_done` and `rd_valid` are low.
- R2: After reset the controller sends only NOPs for at least ceil(T_INIT/tCK) cycles. It then sends a precharge with A10 high, then INIT_REFS auto-refreshes, then one mode-register load. `init_done` is low before the mode load and high from the mode-load cycle on.
- R3: The mode-register load drives bank bits 0 and address bits 12..10 to 0. A9 is 0, so writes use the read burst setting. A[6:4] holds CAS_LAT. A3 is 0 (sequential). A[2:0] is 000 (burst of one).
- R4: Each nanosecond delay is rounded up to whole clocks (18 ns gives 2, 66 ns gives 7 at 10 ns). The column command comes exactly ceil(tRCD/tCK) cycles after its activate. No command comes within ceil(tRFC/tCK) cycles of an auto-refresh, and the two power-up refreshes are exactly that far apart.
- R5: `req_ready` is high only when the controller can start an access. A request is taken when `req_valid` and `req_ready` are both high at a rising edge. Each taken request gives one activate in the next cycle, with the bank from `req_addr[24:23]` and the row from `req_addr[22:10]`. The column command to the same bank follows, with the column from `req_addr[9:0]` on A[9:0] and A[12:11] at 0. It is a write when `req_write` is 1 and a read otherwise. A10 is 1 when AUTO_PRE is 1.
- R6: An activate goes only to a closed bank, and only at least ceil(tRP/tCK) cycles after that bank's precharge began. A read or write goes only to an open bank. With auto-precharge, precharge begins ceil(tWR/tCK) cycles after the column command.
- R7: An auto-refresh is issued only when every bank has been precharged for at least tRP. Refreshes are spaced no more than floor(tREFI/tCK) cycles plus the service delay of one access (at most 16 cycles).
- R8: A due refresh takes priority over waiting requests. Under back-to-back traffic with `req_valid` held high, refreshes keep the R7 spacing.
- R9: For each read, `rd_valid` is high for exactly one cycle, CAS_LAT-1 cycles after the cycle in which the read command is on the pins. It stays low for writes.
- R10: When idle with no request and no refresh due, clock enable goes low. While it is low, and in the first cycle after it rises, the pins carry NOP.
- R11: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as: load mode 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. NOP is driven on every cycle without a command, and no other code is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | {bank[1:0], row[12:0], column[9:0]} |
| init_done | output | 1 | Power-up sequence complete |
| rd_valid | output | 1 | Read data valid on device pins this cycle |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, column or mode address |

## Verification
The embedded assertions watch local rules on every cycle. No command is sent while clock enable is low or just after it rises. Every accepted request is followed by an activate. The mode load carries zero in its upper fields. The delay counter is never reloaded while it is still running. The refresh request is never dropped, and the read strobe is a single-cycle pulse. The multi-cycle protocol is shown only by the bench's device model during its scenarios: per-bank open and closed state, the exact and minimum spacings, the power-up order, refresh spacing under saturating traffic and after power-down, and the mapping of request fields onto pins.

// File: rtl/sdram_ctrl_pkg.sv
// Shared command codes, controller states and delay conversion.
// Assumes: command bits are ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_ctrl_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_INIT_PRE,
        ST_INIT_REF,
        ST_INIT_MRS,
        ST_IDLE,
        ST_COL,
        ST_PRE,
        ST_PDOWN
    } ctrl_state_e;

    // Smallest clock count that covers a delay given in picoseconds.
    function automatic int ceil_cycles(input int dly_ps, input int clk_ps);
        return (dly_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that enforces the minimum spacing between commands.
// Loading N means the next command may go out N+1 cycles after the one
// that loaded it. Assumes the loader only loads when the count is spent.
module sdram_gap_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, or take a new spacing.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R4: a spacing is never cut short by a reload.
    a_r4_load_when_expired: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done);

endmodule

// File: rtl/sdram_refresh_timer.sv
// Periodic refresh request. Raises pending once per INTERVAL cycles while
// enabled. Pending is held until acknowledged. Assumes service is much
// shorter than the interval.
module sdram_refresh_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] TOP = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          tick;

    assign tick = enable && (cnt_q == '0);

    // Interval counter, reloaded on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= TOP;
        else if (tick)         cnt_q <= TOP;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    // Request flag, set by the tick and cleared by the service.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else          pend_q <= tick | (pend_q & ~ack);
    end

    assign pending = pend_q;

    // R7: only a real request is serviced.
    a_r7_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pend_q);
    // R7: a new interval never starts while the last refresh is still owed.
    a_r7_no_missed_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !pend_q);

endmodule

// File: rtl/sdram_rdlat_pipe.sv
// Delay line that turns a read on the pins into a data-valid strobe,
// CAS_LAT-1 cycles later. Assumes reads are spaced further than CAS_LAT.
module sdram_rdlat_pipe #(
    parameter int CAS_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_on_pins,
    output logic rd_valid
);
    generate
        if (CAS_LAT <= 1) begin : g_direct
            assign rd_valid = rd_on_pins;
        end else begin : g_shift
            logic [CAS_LAT-2:0] sr_q;
            // Shift the read marker one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[CAS_LAT-2:0], rd_on_pins} >> 0;
            end
            assign rd_valid = sr_q[CAS_LAT-2];
        end
    endgenerate

    // R9: each read gives a single-cycle strobe.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
// Single-bank-at-a-time SDR SDRAM command controller with closed-page
// policy, power-up sequence, periodic auto-refresh and idle power-down.
// Assumes the device clock is clk, the row width equals the address pin
// count, and the column fits below A10.
module sdram_cmd_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int CLK_PS     = 10000,
    parameter int T_INIT_PS  = 100000000,
    parameter int T_RP_PS    = 18000,
    parameter int T_RCD_PS   = 18000,
    parameter int T_RFC_PS   = 66000,
    parameter int T_WR_PS    = 15000,
    parameter int T_REFI_PS  = 7812500,
    parameter int MRD_CYC    = 2,
    parameter int CAS_LAT    = 3,
    parameter int INIT_REFS  = 2,
    parameter bit AUTO_PRE   = 1'b1,
    parameter bit PD_EN      = 1'b1,
    parameter int BA_W       = 2,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [BA_W+ROW_W+COL_W-1:0]  req_addr,
    output logic                         init_done,
    output logic                         rd_valid,
    output logic                         sd_cke,
    output logic                         sd_cs_n,
    output logic                         sd_ras_n,
    output logic                         sd_cas_n,
    output logic                         sd_we_n,
    output logic [BA_W-1:0]              sd_ba,
    output logic [ROW_W-1:0]             sd_addr
);
    localparam int ADDR_W   = BA_W + ROW_W + COL_W;
    localparam int INIT_CYC = ceil_cycles(T_INIT_PS, CLK_PS);
    localparam int RP_CYC   = ceil_cycles(T_RP_PS, CLK_PS);
    localparam int RCD_CYC  = ceil_cycles(T_RCD_PS, CLK_PS);
    localparam int RFC_CYC  = ceil_cycles(T_RFC_PS, CLK_PS);
    localparam int WR_CYC   = ceil_cycles(T_WR_PS, CLK_PS);
    localparam int REFI_CYC = T_REFI_PS / CLK_PS;
    localparam int GAP_W    = $clog2(INIT_CYC + RFC_CYC + WR_CYC + RP_CYC + MRD_CYC + 1);

    localparam logic [GAP_W-1:0] G_INIT = GAP_W'(INIT_CYC - 1);
    localparam logic [GAP_W-1:0] G_RP   = GAP_W'(RP_CYC - 1);
    localparam logic [GAP_W-1:0] G_RCD  = GAP_W'(RCD_CYC - 1);
    localparam logic [GAP_W-1:0] G_RFC  = GAP_W'(RFC_CYC - 1);
    localparam logic [GAP_W-1:0] G_MRD  = GAP_W'(MRD_CYC - 1);
    localparam logic [GAP_W-1:0] G_WR   = GAP_W'(WR_CYC - 1);
    localparam logic [GAP_W-1:0] G_WRRP = GAP_W'(WR_CYC + RP_CYC - 1);

    // Mode word: upper bits zero, writes follow read burst, CAS latency,
    // sequential order, burst of one.
    localparam logic [ROW_W-1:0] MODE_WORD =
        ROW_W'({3'b000, 1'b0, 2'b00, 3'(CAS_LAT), 1'b0, 3'b000});

    ctrl_state_e          state_q, state_d;
    sd_cmd_e              cmd_q, cmd_d;
    logic [BA_W-1:0]      ba_q, ba_d;
    logic [ROW_W-1:0]     addr_q, addr_d;
    logic                 cke_q, cke_d;
    logic [3:0]           left_q, left_d;
    logic [COL_W-1:0]     col_q;
    logic                 wr_q;
    logic                 gap_load, gap_done;
    logic [GAP_W-1:0]     gap_val;
    logic                 ref_pend, ref_ack;
    logic                 accept;

    wire [BA_W-1:0]  req_bank = req_addr[ADDR_W-1 -: BA_W];
    wire [ROW_W-1:0] req_row  = req_addr[COL_W +: ROW_W];
    wire [COL_W-1:0] req_col  = req_addr[COL_W-1:0];

    sdram_gap_timer #(.CNT_W(GAP_W)) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .done     (gap_done)
    );

    sdram_refresh_timer #(.INTERVAL(REFI_CYC)) i_refi (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (init_done),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    sdram_rdlat_pipe #(.CAS_LAT(CAS_LAT)) i_rdlat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_on_pins (cmd_q == CMD_RD),
        .rd_valid   (rd_valid)
    );

    // Requests are taken only when idle, spaced out, and no refresh is owed.
    assign req_ready = (state_q == ST_IDLE) && gap_done && !ref_pend;
    assign accept    = req_ready && req_valid;
    assign init_done = (state_q == ST_IDLE) || (state_q == ST_COL) ||
                       (state_q == ST_PRE)  || (state_q == ST_PDOWN);

    // Next command, pin values and spacing for the coming edge.
    always_comb begin
        state_d  = state_q;
        cmd_d    = CMD_NOP;
        ba_d     = ba_q;
        addr_d   = addr_q;
        cke_d    = cke_q;
        left_d   = left_q;
        gap_load = 1'b0;
        gap_val  = '0;
        ref_ack  = 1'b0;
        if (gap_done) begin
            case (state_q)
                ST_PWRUP: begin
                    gap_load = 1'b1;
                    gap_val  = G_INIT;
                    state_d  = ST_INIT_PRE;
                end
                ST_INIT_PRE: begin
                    cmd_d      = CMD_PRE;
                    ba_d       = '0;
                    addr_d     = '0;
                    addr_d[10] = 1'b1;
                    gap_load   = 1'b1;
                    gap_val    = G_RP;
                    left_d     = 4'(INIT_REFS);
                    state_d    = ST_INIT_REF;
                end
                ST_INIT_REF: begin
                    cmd_d    = CMD_REF;
                    gap_load = 1'b1;
                    gap_val  = G_RFC;
                    left_d   = left_q - 4'd1;
                    if (left_q <= 4'd1) state_d = ST_INIT_MRS;
                end
                ST_INIT_MRS: begin
                    cmd_d    = CMD_LMR;
                    ba_d     = '0;
                    addr_d   = MODE_WORD;
                    gap_load = 1'b1;
                    gap_val  = G_MRD;
                    state_d  = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        cmd_d    = CMD_REF;
                        ref_ack  = 1'b1;
                        gap_load = 1'b1;
                        gap_val  = G_RFC;
                    end else if (req_valid) begin
                        cmd_d    = CMD_ACT;
                        ba_d     = req_bank;
                        addr_d   = req_row;
                        gap_load = 1'b1;
                        gap_val  = G_RCD;
                        state_d  = ST_COL;
                    end else if (PD_EN) begin
                        cke_d    = 1'b0;
                        state_d  = ST_PDOWN;
                    end
                end
                ST_COL: begin
                    cmd_d              = wr_q ? CMD_WR : CMD_RD;
                    addr_d             = '0;
                    addr_d[COL_W-1:0]  = col_q;
                    addr_d[10]         = AUTO_PRE;
                    gap_load           = 1'b1;
                    gap_val            = AUTO_PRE ? G_WRRP : G_WR;
                    state_d            = AUTO_PRE ? ST_IDLE : ST_PRE;
                end
                ST_PRE: begin
                    cmd_d      = CMD_PRE;
                    addr_d[10] = 1'b0;
                    gap_load   = 1'b1;
                    gap_val    = G_RP;
                    state_d    = ST_IDLE;
                end
                ST_PDOWN: begin
                    if (ref_pend || req_valid) begin
                        cke_d   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_PWRUP;
            endcase
        end
    end

    // Register state and all device pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
            cmd_q   <= CMD_NOP;
            ba_q    <= '0;
            addr_q  <= '0;
            cke_q   <= 1'b1;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            ba_q    <= ba_d;
            addr_q  <= addr_d;
            cke_q   <= cke_d;
            left_q  <= left_d;
        end
    end

    // Hold the column part of a taken request until its column command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            col_q <= req_col;
            wr_q  <= req_write;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_cke  = cke_q;
    assign sd_ba   = ba_q;
    assign sd_addr = addr_q;

    // R10: commands only while the clock enable is, and was, high.
    a_r10_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |-> (cke_q && $past(cke_q)));
    // R5: every taken request opens its row on the next cycle.
    a_r5_accept_gives_act: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_q == CMD_ACT));
    // R3: mode load keeps bank and upper address bits at zero.
    a_r3_mode_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_LMR) |-> (sd_ba == '0 && sd_addr[12:10] == 3'b000));

endmodule

// File: tb/test_sdram_cmd_ctrl.sv
// Bench: a behavioural device model checks every command on the pins
// against per-bank state and timing, and compares rd_valid every cycle.
module test_sdram_cmd_ctrl;
    localparam int INIT  = 10000;   // 100 us at 10 ns
    localparam int RP    = 2;       // 18 ns rounded up
    localparam int RCD   = 2;
    localparam int RFC   = 7;       // 66 ns rounded up
    localparam int WR    = 2;       // 15 ns rounded up
    localparam int REFI  = 781;     // 7812.5 ns rounded down
    localparam int CL    = 3;
    localparam int SLACK = 16;
    localparam logic [12:0] MODE = 13'h030;

    localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_ready, init_done, rd_valid, sd_cke;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    sdram_cmd_ctrl i_sdram_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .init_done(init_done),
        .rd_valid(rd_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Device model state.
    int cyc = 0, last_cmd = -100, stage = 0, ref_busy = -100, last_ref = 0;
    int ref_cnt = 0, rd_cnt = 0;
    bit open_b[4];
    int act_at[4];
    int pre_at[4];
    bit prev_cke = 1'b1, pd_seen = 1'b0, hs_seen = 1'b0;
    int qb[$], qr[$], qc[$], qw[$], rdq[$];
    int cb = 0, cc = 0, cw = 0;

    initial for (int b = 0; b < 4; b++) begin
        open_b[b] = 1'b0; act_at[b] = -100; pre_at[b] = -100;
    end

    // Per-cycle model, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] cmd;
            bit exp_rv;
            cyc++;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            exp_rv = (rdq.size() > 0) && (rdq[0] == cyc);
            if (exp_rv) void'(rdq.pop_front());
            chk(rd_valid == exp_rv, "R9", "rd_valid", int'(rd_valid), int'(exp_rv));
            if (!sd_cke || !prev_cke)
                chk(cmd == C_NOP, "R10", "command near low cke", int'(cmd), int'(C_NOP));
            if (!sd_cke) pd_seen = 1'b1;
            if (cmd != C_NOP) begin
                chk(cyc >= ref_busy, "R4", "command inside tRFC", cyc, ref_busy);
                case (cmd)
                    C_PRE: begin
                        if (stage == 0) begin
                            chk(cyc >= INIT, "R2", "power-up wait", cyc, INIT);
                            chk(sd_addr[10], "R2", "precharge-all A10", int'(sd_addr[10]), 1);
                            chk(!init_done, "R2", "init_done early", int'(init_done), 0);
                            for (int b = 0; b < 4; b++) begin open_b[b] = 0; pre_at[b] = cyc; end
                            stage = 1;
                        end else begin
                            chk(open_b[sd_ba], "R6", "precharge of closed bank", 0, 1);
                            open_b[sd_ba] = 0; pre_at[sd_ba] = cyc;
                        end
                    end
                    C_REF: begin
                        for (int b = 0; b < 4; b++)
                            chk(!open_b[b] && cyc >= pre_at[b] + RP, "R7",
                                "refresh with bank not precharged", cyc, pre_at[b] + RP);
                        ref_busy = cyc + RFC;
                        if (stage == 1) stage = 2;
                        else if (stage == 2) begin
                            chk(cyc - last_cmd == RFC, "R4", "init refresh spacing",
                                cyc - last_cmd, RFC);
                            stage = 3;
                        end else begin
                            chk(stage == 4, "R2", "refresh order", stage, 4);
                            chk(cyc - last_ref <= REFI + SLACK, "R7", "refresh spacing",
                                cyc - last_ref, REFI + SLACK);
                            last_ref = cyc; ref_cnt++;
                        end
                    end
                    C_LMR: begin
                        chk(stage == 3, "R2", "mode load order", stage, 3);
                        chk(sd_ba == 2'b00, "R3", "mode load bank", int'(sd_ba), 0);
                        chk(sd_addr == MODE, "R3", "mode word", int'(sd_addr), int'(MODE));
                        chk(init_done, "R2", "init_done at mode load", int'(init_done), 1);
                        stage = 4; last_ref = cyc;
                    end
                    C_ACT: begin
                        chk(stage == 4, "R2", "activate before init", stage, 4);
                        chk(!open_b[sd_ba] && cyc >= pre_at[sd_ba] + RP, "R6",
                            "activate timing", cyc, pre_at[sd_ba] + RP);
                        chk(qb.size() > 0, "R5", "activate without request", qb.size(), 1);
                        if (qb.size() > 0) begin
                            cb = qb.pop_front(); cc = qc.pop_front(); cw = qw.pop_front();
                            chk(int'(sd_ba) == cb, "R5", "activate bank", int'(sd_ba), cb);
                            chk(int'(sd_addr) == qr.pop_front(), "R5", "activate row",
                                int'(sd_addr), -1);
                        end
                        open_b[sd_ba] = 1; act_at[sd_ba] = cyc;
                    end
                    C_RD, C_WR: begin
                        chk(open_b[sd_ba], "R6", "column to closed bank", 0, 1);
                        chk(cyc - act_at[sd_ba] == RCD, "R4", "activate to column",
                            cyc - act_at[sd_ba], RCD);
                        chk(int'(sd_ba) == cb, "R5", "column bank", int'(sd_ba), cb);
                        chk(int'(sd_addr[9:0]) == cc, "R5", "column", int'(sd_addr[9:0]), cc);
                        chk(sd_addr[12:10] == 3'b001, "R5", "A12..A10",
                            int'(sd_addr[12:10]), 1);
                        chk(int'(cmd == C_WR) == cw, "R5", "read/write kind",
                            int'(cmd == C_WR), cw);
                        if (cmd == C_RD) begin rdq.push_back(cyc + CL - 1); rd_cnt++; end
                        open_b[sd_ba] = 0; pre_at[sd_ba] = cyc + WR;
                    end
                    default: chk(1'b0, "R11", "illegal command code", int'(cmd), int'(C_NOP));
                endcase
                last_cmd = cyc;
            end
            if (req_ready)
                chk(init_done && sd_cke, "R5", "ready outside idle", int'(init_done), 1);
            if (req_valid && req_ready) begin
                qb.push_back(int'(req_addr[24:23]));
                qr.push_back(int'(req_addr[22:10]));
                qc.push_back(int'(req_addr[9:0]));
                qw.push_back(int'(req_write));
                hs_seen = 1'b1;
            end
            prev_cke = sd_cke;
        end
    end

    task automatic do_req(input int b, input int r, input int c, input bit w);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = {b[1:0], r[12:0], c[9:0]};
        do begin @(posedge clk); #1; end while (!hs_seen);
        hs_seen = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Scenarios.
    initial begin
        int refs_before;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state.
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "reset command",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
        chk(sd_cke, "R1", "reset cke", int'(sd_cke), 1);
        chk(!req_ready && !init_done && !rd_valid, "R1", "reset outputs",
            int'({req_ready, init_done, rd_valid}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!init_done && !req_ready, "R1", "after reset", int'({init_done, req_ready}), 0);
        while (!init_done) begin @(posedge clk); #1; end

        // Single requests with idle gaps (power-down between them).
        for (int i = 0; i < 8; i++) begin
            do_req(i % 4, (i * 977 + 13) % 8192, (i * 37) % 1024, (i % 3) == 0);
            idle(12);
        end
        // R8: back-to-back traffic with valid held high.
        refs_before = ref_cnt;
        for (int i = 0; i < 400; i++)
            do_req((i * 3) % 4, (i * 1231 + 7) % 8192, (i * 53 + 1) % 1024, (i % 2) == 1);
        chk(ref_cnt - refs_before >= 2, "R8", "refreshes under traffic",
            ref_cnt - refs_before, 2);
        // Long idle: refreshes must wake the device out of power-down.
        refs_before = ref_cnt;
        idle(2500);
        chk(ref_cnt - refs_before >= 3, "R7", "refreshes while idle",
            ref_cnt - refs_before, 3);
        chk(pd_seen, "R10", "power-down entered", int'(pd_seen), 1);
        chk(!sd_cke, "R10", "cke low when idle", int'(sd_cke), 0);
        // A few more reads after power-down.
        for (int i = 0; i < 4; i++) begin
            do_req(3 - i, 8191 - i, 1023 - i, 1'b0);
            idle(3);
        end
        idle(20);
        chk(qb.size() == 0, "R5", "requests never activated", qb.size(), 0);
        chk(rdq.size() == 0, "R9", "read strobes missing", rdq.size(), 0);
        chk(rd_cnt > 100, "R9", "reads observed", rd_cnt, 100);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
            summary();
            $finish;
        end
    end

endmodule